// File: doc/BRIEF.md
# Double-buffered SPI controller with status flags and interrupts

This block is a serial peripheral port that can run as bus master or as a selected slave. Software talks to it over a small register bus. A write to the data register fills a transmit holding buffer. The shift engine takes that byte into its shifter whenever it is free. Each received byte lands in a separate receive holding buffer. Because of this, software can queue the next byte while the current one is still on the wire, and it has a full byte-time in which to collect the received data.

Four status flags record the state of the port: transmit-empty, receive-full, overflow and mode-fault. Two interrupt lines are built from them. The transmit line follows transmit-empty. The second line is shared: receive-full raises it under its own enable, and overflow and mode-fault raise it under a separate error enable. In master mode the slave-select input is watched for a competing master. This watch can be switched off. When it is off, only overflow can raise an error.

Transfers are 8 bits, most significant bit first. The clock idles low. Data is sampled on the rising edge and changed on the falling edge. In master mode each half-period of SCK lasts `2**DIV_LOG2` system clocks. All serial inputs pass through a synchronizer of `SYNC_STAGES` flops.

Top module: `spi_dbuf_ctrl`

## Requirements
- R1: After reset, the control register reads 0, the status register reads 0x01, both interrupt outputs are 0, and all three output enables are 0.
- R2: A master transfer shifts out 8 bits MSB first on mosi_o. It samples miso_i on each rising edge of sck_o. The received byte equals the bits presented on miso_i. Two consecutive rising edges within a byte are 2*2**DIV_LOG2 (8 by default) clocks apart.
- R3: Writing the data register clears transmit-empty (status bit 0). Transmit-empty sets again when the shifter takes the byte. A byte written while a transfer is running goes out directly after it.
- R4: Receive-full (status bit 1) sets when a completed byte enters the receive buffer. A read of the data register clears it.
- R5: If a byte completes while receive-full is still set, overflow (status bit 2) sets, the buffered byte is kept and the new byte is lost. Writing 1 to status bit 2 clears overflow.
- R6: tx_irq_o is 1 exactly when transmit-empty, the transmit interrupt enable (control bit 2) and the module enable (control bit 0) are all 1.
- R7: Receive-full drives rx_err_irq_o only while the receive interrupt enable (control bit 3) and the module enable are both 1.
- R8: When the error enable (control bit 4) is 1, overflow or mode-fault drives rx_err_irq_o, whatever the module enable. When control bit 4 is 0, neither of them does.
- R9: In master mode (control bit 1 = 1), with the module enabled and detection on (control bit 5 = 1), ss_n_i held low sets mode-fault (status bit 3). This also clears the module enable and drops sck_oe_o and mosi_oe_o. Writing 1 to status bit 3 clears mode-fault.
- R10: With detection off (control bit 5 = 0), mode-fault never sets. A low ss_n_i in master mode then leaves the module enable and the output enables unchanged.
- R11: In slave mode (control bit 1 = 0), a low ss_n_i selects the port and raises miso_oe_o. The buffered transmit byte is shifted out on miso_o MSB first. The byte on mosi_i, sampled on rising edges of sck_i, is received.
- R12: The register map is: address 0 = control (bits 5..0 as above, read back as written); address 1 = status (bits 3..0, write-1-to-clear on bits 2 and 3); address 2 = data (a write fills the transmit buffer, a read returns the receive buffer).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| ss_n_i | input | 1 | Slave select, active low |
| sck_i | input | 1 | Serial clock in (slave mode) |
| mosi_i | input | 1 | Serial data in (slave mode) |
| miso_i | input | 1 | Serial data in (master mode) |
| sck_o | output | 1 | Serial clock out (master mode) |
| sck_oe_o | output | 1 | Drive enable for sck_o |
| mosi_o | output | 1 | Serial data out (master mode) |
| mosi_oe_o | output | 1 | Drive enable for mosi_o |
| miso_o | output | 1 | Serial data out (slave mode) |
| miso_oe_o | output | 1 | Drive enable for miso_o |
| tx_irq_o | output | 1 | Transmitter interrupt request |
| rx_err_irq_o | output | 1 | Receiver/error interrupt request |

## Verification
The bench streams sixteen bytes back to back, writing each next byte while the previous one is still shifting. A design that let the shifter's load win over a data write, or that released transmit-empty too early, would drop or repeat bytes in the comparison. Two bytes are then completed without a read in between. A design that overwrote the buffer on overflow would return the second byte instead of the first. The mode-fault cases are run with detection on and with detection off, and the error line is checked while the module enable has just been cleared. A design that gated errors with the enable, or that set mode-fault with detection off, shows a wrong interrupt or a cleared enable. A slave exchange driven from the bench checks the select-driven output enable and both data directions.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } eng_state_t;

    // Packed with en at bit 0, up to modf_en at bit 5.
    typedef struct packed {
        logic modf_en;
        logic err_ie;
        logic rx_ie;
        logic tx_ie;
        logic master;
        logic en;
    } ctrl_t;

    localparam int          CTRL_W    = 6;
    localparam logic [1:0]  ADDR_CTRL = 2'd0;
    localparam logic [1:0]  ADDR_STAT = 2'd1;
    localparam logic [1:0]  ADDR_DATA = 2'd2;
    localparam int          BIT_OVR   = 2;
    localparam int          BIT_MODF  = 3;
endpackage

// File: rtl/spi_dbuf_engine.sv
module spi_dbuf_engine
    import spi_dbuf_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int DIV_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              master,
    input  logic              tx_pend,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              ss_act,
    input  logic              sck_s,
    input  logic              mosi_s,
    input  logic              miso_s,
    output logic              load,
    output logic              done,
    output logic [DATA_W-1:0] rx_byte,
    output logic              sck_o,
    output logic              sdo
);
    localparam int BCW = $clog2(DATA_W);

    eng_state_t          state, state_nx;
    logic [DIV_LOG2-1:0] div_cnt;
    logic [BCW-1:0]      bit_cnt;
    logic [DATA_W-1:0]   shreg;
    logic                samp, sck_q, done_q;
    logic                div_end, sck_rise, sck_fall, start, abort;
    logic                edge_lead, edge_trail, last;

    assign div_end    = &div_cnt;
    assign sck_rise   = sck_s & ~sck_q;
    assign sck_fall   = ~sck_s & sck_q;
    assign start      = en & (master ? tx_pend : ss_act);
    assign abort      = ~en | (~master & ~ss_act);
    assign edge_lead  = master ? div_end : sck_rise;
    assign edge_trail = master ? div_end : sck_fall;
    assign last       = (bit_cnt == BCW'(DATA_W - 1));

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_LOW;
            ST_LOW: begin
                if (abort)          state_nx = ST_IDLE;
                else if (edge_lead) state_nx = ST_HIGH;
            end
            ST_HIGH: begin
                if (abort)           state_nx = ST_IDLE;
                else if (edge_trail) state_nx = last ? ST_IDLE : ST_LOW;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
            bit_cnt <= '0;
            shreg   <= '0;
            samp    <= 1'b0;
            sck_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            sck_q  <= sck_s;
            done_q <= 1'b0;
            if (state == ST_IDLE) begin
                div_cnt <= '0;
                bit_cnt <= '0;
                if (start && tx_pend) shreg <= tx_data;
            end else if (!abort) begin
                div_cnt <= div_cnt + 1'b1;
                if (state == ST_LOW && edge_lead)
                    samp <= master ? miso_s : mosi_s;
                if (state == ST_HIGH && edge_trail) begin
                    shreg   <= {shreg[DATA_W-2:0], samp};
                    bit_cnt <= bit_cnt + 1'b1;
                    done_q  <= last;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        load    = (state == ST_IDLE) && start && tx_pend;
        done    = done_q;
        rx_byte = shreg;
        sck_o   = master && (state == ST_HIGH);
        sdo     = shreg[DATA_W-1];
    end
endmodule

// File: rtl/spi_dbuf_regs.sv
module spi_dbuf_regs
    import spi_dbuf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              load,
    input  logic              done,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              ss_act,
    output ctrl_t             ctrl,
    output logic              txe,
    output logic              rxf,
    output logic              ovr,
    output logic              modf,
    output logic [DATA_W-1:0] tx_data,
    output logic [DATA_W-1:0] rx_data
);
    logic wr_ctrl, wr_stat, wr_data, rd_data, modf_set;

    assign wr_ctrl  = bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_stat  = bus_wr && (bus_addr == ADDR_STAT);
    assign wr_data  = bus_wr && (bus_addr == ADDR_DATA);
    assign rd_data  = bus_rd && (bus_addr == ADDR_DATA);
    assign modf_set = ctrl.en & ctrl.master & ctrl.modf_en & ss_act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl    <= '0;
            txe     <= 1'b1;
            rxf     <= 1'b0;
            ovr     <= 1'b0;
            modf    <= 1'b0;
            tx_data <= '0;
            rx_data <= '0;
        end else begin
            if (wr_ctrl) ctrl <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            if (modf_set) begin
                modf    <= 1'b1;
                ctrl.en <= 1'b0;
            end else if (wr_stat && bus_wdata[BIT_MODF]) begin
                modf <= 1'b0;
            end
            if (wr_data) begin
                tx_data <= bus_wdata;
                txe     <= 1'b0;
            end else if (load) begin
                txe <= 1'b1;
            end
            if (wr_stat && bus_wdata[BIT_OVR]) ovr <= 1'b0;
            if (done) begin
                if (rxf && !rd_data) begin
                    ovr <= 1'b1;
                end else begin
                    rx_data <= rx_byte;
                    rxf     <= 1'b1;
                end
            end else if (rd_data) begin
                rxf <= 1'b0;
            end
        end
    end

    always_comb begin
        case (bus_addr)
            ADDR_CTRL: bus_rdata = DATA_W'(ctrl);
            ADDR_STAT: bus_rdata = DATA_W'({modf, ovr, rxf, txe});
            ADDR_DATA: bus_rdata = rx_data;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spi_dbuf_irq.sv
module spi_dbuf_irq
    import spi_dbuf_pkg::*;
(
    input  ctrl_t ctrl,
    input  logic  txe,
    input  logic  rxf,
    input  logic  ovr,
    input  logic  modf,
    output logic  tx_irq,
    output logic  rx_err_irq
);
    always_comb begin
        tx_irq     = txe & ctrl.tx_ie & ctrl.en;
        rx_err_irq = (rxf & ctrl.rx_ie & ctrl.en) | (ctrl.err_ie & (ovr | modf));
    end
endmodule

// File: rtl/spi_dbuf_ctrl.sv
module spi_dbuf_ctrl
    import spi_dbuf_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DIV_LOG2    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ss_n_i,
    input  logic              sck_i,
    input  logic              mosi_i,
    input  logic              miso_i,
    output logic              sck_o,
    output logic              sck_oe_o,
    output logic              mosi_o,
    output logic              mosi_oe_o,
    output logic              miso_o,
    output logic              miso_oe_o,
    output logic              tx_irq_o,
    output logic              rx_err_irq_o
);
    localparam int NSYNC = 4;
    localparam logic [NSYNC-1:0] SYNC_RST = 4'b1000;

    logic [SYNC_STAGES-1:0][NSYNC-1:0] sync_q;
    logic              ss_n_s, sck_s, mosi_s, miso_s, ss_act;
    ctrl_t             ctrl;
    logic              txe, rxf, ovr, modf;
    logic              eng_load, eng_done, eng_sck, eng_sdo;
    logic [DATA_W-1:0] tx_data, rx_data, rx_byte;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= {SYNC_STAGES{SYNC_RST}};
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], {ss_n_i, sck_i, mosi_i, miso_i}};
    end
    assign {ss_n_s, sck_s, mosi_s, miso_s} = sync_q[SYNC_STAGES-1];
    assign ss_act = ~ss_n_s;

    spi_dbuf_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .load(eng_load), .done(eng_done), .rx_byte(rx_byte), .ss_act(ss_act),
        .ctrl(ctrl), .txe(txe), .rxf(rxf), .ovr(ovr), .modf(modf),
        .tx_data(tx_data), .rx_data(rx_data)
    );

    spi_dbuf_engine #(.DATA_W(DATA_W), .DIV_LOG2(DIV_LOG2)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .en(ctrl.en), .master(ctrl.master), .tx_pend(~txe), .tx_data(tx_data),
        .ss_act(ss_act), .sck_s(sck_s), .mosi_s(mosi_s), .miso_s(miso_s),
        .load(eng_load), .done(eng_done), .rx_byte(rx_byte),
        .sck_o(eng_sck), .sdo(eng_sdo)
    );

    spi_dbuf_irq u_irq (
        .ctrl(ctrl), .txe(txe), .rxf(rxf), .ovr(ovr), .modf(modf),
        .tx_irq(tx_irq_o), .rx_err_irq(rx_err_irq_o)
    );

    assign sck_o     = eng_sck;
    assign mosi_o    = eng_sdo;
    assign miso_o    = eng_sdo;
    assign sck_oe_o  = ctrl.en & ctrl.master;
    assign mosi_oe_o = ctrl.en & ctrl.master;
    assign miso_oe_o = ctrl.en & ~ctrl.master & ss_act;
endmodule

// File: rtl/spi_dbuf_chk.sv
module spi_dbuf_chk
    import spi_dbuf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic              load,
    input logic              done,
    input ctrl_t             ctrl,
    input logic              txe,
    input logic              rxf,
    input logic              ovr,
    input logic              modf,
    input logic [DATA_W-1:0] rx_data,
    input logic              sck_oe,
    input logic              miso_oe,
    input logic              tx_irq
);
    logic wr_data, rd_data;
    assign wr_data = bus_wr && (bus_addr == ADDR_DATA);
    assign rd_data = bus_rd && (bus_addr == ADDR_DATA);

    p_load_sets_txe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !wr_data) |=> txe);

    p_rxf_on_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !rxf) |=> rxf);

    p_no_overwrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rxf && !rd_data) |=> (ovr && $stable(rx_data)));

    p_txirq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> (ctrl.en && ctrl.tx_ie && txe));

    p_modf_drops_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(modf) |-> (!ctrl.en && !sck_oe));

    p_no_modf_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.modf_en && !modf) |=> !modf);

    p_oe_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sck_oe, miso_oe}));
endmodule

bind spi_dbuf_ctrl spi_dbuf_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .load(eng_load), .done(eng_done), .ctrl(ctrl), .txe(txe), .rxf(rxf),
    .ovr(ovr), .modf(modf), .rx_data(rx_data), .sck_oe(sck_oe_o),
    .miso_oe(miso_oe_o), .tx_irq(tx_irq_o)
);

// File: tb/tb_spi_dbuf_ctrl.sv
module tb_spi_dbuf_ctrl;
    localparam int NB = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ss_n_i = 1'b1, sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0;
    logic       sck_o, sck_oe_o, mosi_o, mosi_oe_o, miso_o, miso_oe_o;
    logic       tx_irq_o, rx_err_irq_o;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    longint cyc = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    spi_dbuf_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ss_n_i(ss_n_i), .sck_i(sck_i),
        .mosi_i(mosi_i), .miso_i(miso_i), .sck_o(sck_o), .sck_oe_o(sck_oe_o),
        .mosi_o(mosi_o), .mosi_oe_o(mosi_oe_o), .miso_o(miso_o), .miso_oe_o(miso_oe_o),
        .tx_irq_o(tx_irq_o), .rx_err_irq_o(rx_err_irq_o)
    );

    function automatic logic [7:0] mst_pat(input int j);
        return 8'((j * 37 + 11) & 255);
    endfunction
    function automatic logic [7:0] slv_pat(input int j);
        return 8'((j * 53 + 7) & 255);
    endfunction

    // Slave model for master-mode transfers: mode 0, MSB first
    int         bs_bit = 0, bs_idx = 0;
    logic [7:0] mosi_cap = '0;
    logic [7:0] mosi_log [32];
    longint     rise_prev = 0, rise_last = 0;

    always @(posedge sck_o) begin
        if (rst_n) begin
            mosi_cap  = {mosi_cap[6:0], mosi_o};
            rise_prev = rise_last;
            rise_last = cyc;
        end
    end
    always @(negedge sck_o) begin
        if (rst_n) begin
            bs_bit++;
            if (bs_bit == 8) begin
                if (bs_idx < 32) mosi_log[bs_idx] = mosi_cap;
                bs_idx++;
                bs_bit = 0;
            end
            miso_i = slv_pat(bs_idx)[7 - bs_bit];
        end
    end

    task automatic chk_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic wait_stat(input int b, input string req);
        logic [7:0] s;
        bit got = 0;
        for (int k = 0; k < 3000 && !got; k++) begin
            bus_read(2'd1, s);
            if (s[b]) got = 1;
        end
        chk_eq(req, int'(got), 1);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] cap;
        int idx0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state, R12 map
        bus_read(2'd0, d); chk_eq("R1 R12 ctrl after reset", d, 0);
        bus_read(2'd1, d); chk_eq("R1 status after reset", d, 8'h01);
        chk_eq("R1 irqs after reset", {tx_irq_o, rx_err_irq_o}, 0);
        chk_eq("R1 oes after reset", {sck_oe_o, mosi_oe_o, miso_oe_o}, 0);

        // R2/R3/R4 back-to-back master sweep
        bus_write(2'd0, 8'h03);
        bus_read(2'd0, d); chk_eq("R12 ctrl readback", d, 8'h03);
        bus_write(2'd2, mst_pat(0));
        for (int j = 1; j <= NB; j++) begin
            if (j < NB) begin
                wait_stat(0, "R3 txe set after load");
                bus_write(2'd2, mst_pat(j));
                bus_read(2'd1, d); chk_eq("R3 txe clear after write", d[0], 0);
            end
            wait_stat(1, "R4 rxf set");
            bus_read(2'd2, d); chk_eq("R2 received byte", d, slv_pat(j - 1));
            bus_read(2'd1, d); chk_eq("R4 rxf clear after read", d[1], 0);
        end
        for (int j = 0; j < NB; j++) chk_eq("R2 mosi byte", mosi_log[j], mst_pat(j));
        chk_eq("R2 sck period", int'(rise_last - rise_prev), 8);

        // R6 transmit interrupt gating
        bus_write(2'd0, 8'h07);
        #1 chk_eq("R6 tx irq enabled", tx_irq_o, 1);
        bus_write(2'd0, 8'h06);
        #1 chk_eq("R6 tx irq module off", tx_irq_o, 0);
        bus_write(2'd0, 8'h03);
        #1 chk_eq("R6 tx irq ie off", tx_irq_o, 0);

        // R7 receive interrupt gating
        bus_write(2'd0, 8'h0B);
        bus_write(2'd2, 8'h5A);
        wait_stat(1, "R4 rxf for R7");
        chk_eq("R7 rx irq", rx_err_irq_o, 1);
        bus_write(2'd0, 8'h0A);
        #1 chk_eq("R7 rx irq module off", rx_err_irq_o, 0);
        bus_read(2'd2, d);

        // R5 overflow and R8 error gating
        bus_write(2'd0, 8'h13);
        idx0 = bs_idx;
        bus_write(2'd2, 8'hC3);
        wait_stat(1, "R4 rxf before overflow");
        bus_write(2'd2, 8'h3C);
        wait_stat(2, "R5 ovr set");
        chk_eq("R8 err irq from ovr", rx_err_irq_o, 1);
        bus_write(2'd0, 8'h03);
        #1 chk_eq("R8 err irq disabled", rx_err_irq_o, 0);
        bus_read(2'd2, d); chk_eq("R5 first byte kept", d, slv_pat(idx0));
        bus_read(2'd1, d); chk_eq("R5 ovr held", d[2], 1);
        bus_write(2'd1, 8'h04);
        bus_read(2'd1, d); chk_eq("R5 ovr w1c", d, 8'h01);

        // R9 mode fault
        bus_write(2'd0, 8'h33);
        ss_n_i = 1'b0;
        repeat (6) @(negedge clk);
        bus_read(2'd1, d); chk_eq("R9 modf set", d[3], 1);
        bus_read(2'd0, d); chk_eq("R9 enable cleared", d, 8'h32);
        chk_eq("R9 outputs released", {sck_oe_o, mosi_oe_o}, 0);
        chk_eq("R8 err irq from modf with module off", rx_err_irq_o, 1);
        ss_n_i = 1'b1;
        repeat (4) @(negedge clk);
        bus_write(2'd1, 8'h08);
        bus_read(2'd1, d); chk_eq("R9 modf w1c", d[3], 0);
        #1 chk_eq("R8 err irq after clear", rx_err_irq_o, 0);

        // R10 detection off
        bus_write(2'd0, 8'h13);
        ss_n_i = 1'b0;
        repeat (6) @(negedge clk);
        bus_read(2'd1, d); chk_eq("R10 modf stays clear", d[3], 0);
        bus_read(2'd0, d); chk_eq("R10 ctrl unchanged", d, 8'h13);
        chk_eq("R10 outputs driven", {sck_oe_o, mosi_oe_o}, 2'b11);
        chk_eq("R10 no err irq", rx_err_irq_o, 0);
        ss_n_i = 1'b1;
        repeat (4) @(negedge clk);

        // R11 slave exchange
        bus_write(2'd0, 8'h01);
        bus_write(2'd2, 8'h3C);
        ss_n_i = 1'b0;
        repeat (4) @(negedge clk);
        chk_eq("R11 miso_oe when selected", miso_oe_o, 1);
        repeat (4) @(negedge clk);
        cap = '0;
        for (int i = 7; i >= 0; i--) begin
            mosi_i = 8'hA6 >> i;
            repeat (8) @(negedge clk);
            sck_i = 1'b1;
            cap = {cap[6:0], miso_o};
            repeat (8) @(negedge clk);
            sck_i = 1'b0;
        end
        repeat (8) @(negedge clk);
        ss_n_i = 1'b1;
        repeat (4) @(negedge clk);
        chk_eq("R11 miso byte", cap, 8'h3C);
        chk_eq("R11 miso_oe released", miso_oe_o, 0);
        bus_read(2'd1, d); chk_eq("R11 rxf", d[1], 1);
        bus_read(2'd2, d); chk_eq("R11 mosi byte received", d, 8'hA6);

        summary();
        finished = 1;
        $finish;
    end
endmodule